// File: doc/BRIEF.md
# Ping-Pong DMA Channel

This block is one DMA channel that alternates between two buffer descriptors. Each descriptor holds a start address and a transfer count. Software loads a peripheral FIFO address, both descriptors and the mode fields, then enables one or both buffers and sets the run bit. For each request from the peripheral, the channel issues one single-beat memory access at the active buffer's address and acknowledges the peripheral when the memory side grants it.

When the active buffer's count runs out, the channel marks that buffer done, drops its enable and turns to the other buffer. Software can therefore refill one buffer while the other one streams. The control word can only be changed through two addresses. A write to the set address turns on the bits written as one. A write to the clear address turns off the bits written as one. A halted status bit reports that the channel has stopped at a unit boundary after run was removed. A level interrupt reports finished buffers.

Top module: `pingpong_dma_chan`

## Requirements
- R1: A write to offset 0x00 sets the control bits written as one. A write to offset 0x04 clears the control bits written as one. Reading offset 0x00 returns the control word with these fields: bit0 enable of buffer 0, bit1 done of buffer 0, bit2 enable of buffer 1, bit3 done of buffer 1, bit4 active buffer, bit5 run, bit6 halted, bit7 interrupt enable, bits 10:9 device width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), bit12 direction (1 = memory write), bits 19:16 device ID. All other bits read as zero. Software cannot change the active-buffer bit or the halted bit.
- R2: After reset the control word reads 0x40, so only halted is set. Both counts read zero and irq is low.
- R3: The peripheral address (0x08), buffer 0 start (0x0C), buffer 0 count (0x10), buffer 1 start (0x14) and buffer 1 count (0x18) read back what was written. A count keeps only bits 15:0. The peripheral address appears on dev_fifo_addr.
- R4: For each transfer unit, mem_req stays high with a stable address until mem_gnt. dev_ack is high in the grant cycle. mem_write equals the direction bit and mem_size equals the width field. On grant, the active count drops by one and the start address advances by 1, 2 or 4 bytes.
- R5: When the active count is zero, the channel sets that buffer's done bit, clears its enable bit and toggles the active-buffer bit, all in one cycle.
- R6: After a switch, the channel keeps transferring from the other buffer if it is enabled. If it is not enabled, the channel issues no request, with run still set, until software enables it.
- R7: An enabled active buffer whose count is zero is marked done without any memory request.
- R8: A done bit stays set until a one is written to it at the clear address. Writing ones to done bits at the set address has no effect.
- R9: irq is high exactly when interrupt enable is set and at least one done bit is set.
- R10: Clearing run lets an outstanding unit finish. Halted rises in the cycle after the channel is idle with run clear. Halted falls in the cycle after run is set.
- R11: No memory request starts while run is clear or the active buffer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| dev_req | input | 1 | Peripheral asks for one unit |
| dev_ack | output | 1 | Unit completed for the peripheral |
| dev_fifo_addr | output | ADDR_W | Programmed peripheral FIFO address |
| mem_req | output | 1 | Single-beat memory request |
| mem_gnt | input | 1 | Memory side accepts the request |
| mem_addr | output | ADDR_W | Active buffer address |
| mem_write | output | 1 | 1 = write to memory, 0 = read |
| mem_size | output | 2 | Unit size code, same as width field |
| irq | output | 1 | Buffer-done interrupt |

## Verification
The bench covers the switch from buffer 0 to buffer 1 and back. If the design toggled the active bit on the wrong edge or failed to clear the enable, the next request would go to a stale address or a finished buffer would run a second time. Buffers are loaded with a zero count; a design that got this wrong would issue a spurious memory access or underflow the count to 0xFFFF. The run bit is cleared while a unit is waiting for its grant, and a design that took this wrong would raise halted early or drop the request midway. Done bits are checked for stickiness, since a design that got it wrong would lose an interrupt or let the set address forge one. The width step is also checked, because a wrong shift would corrupt every address after the first.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int NBUF      = 2;
  localparam int OFF_SET   = 'h00;
  localparam int OFF_CLR   = 'h04;
  localparam int OFF_PADDR = 'h08;
  localparam int OFF_BASE0 = 'h0C;   // buffer b start at OFF_BASE0 + 8*b
  localparam int OFF_CNT0  = 'h10;   // buffer b count at OFF_CNT0 + 8*b
  localparam int OFF_STEP  = 8;

  localparam int B_AB    = 4;
  localparam int B_RUN   = 5;
  localparam int B_HALT  = 6;
  localparam int B_IE    = 7;
  localparam int B_WID   = 9;
  localparam int B_DIR   = 12;
  localparam int B_DEVID = 16;

  typedef enum logic {S_IDLE = 1'b0, S_BUSY = 1'b1} seq_state_e;
endpackage

// File: rtl/dma_buf_desc.sv
`timescale 1ns/1ps
module dma_buf_desc #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  input  logic [2:0]        step_bytes,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              addr_en, cnt_en;

  always_comb begin
    addr_en = ld_addr | step;
    cnt_en  = ld_cnt  | step;
    addr_d  = ld_addr ? ADDR_W'(wdata) : addr_q + ADDR_W'(step_bytes);
    cnt_d   = ld_cnt  ? wdata[CNT_W-1:0] : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic act_en,
  input  logic act_zero,
  input  logic dev_req,
  input  logic mem_gnt,
  output logic mem_req,
  output logic dev_ack,
  output logic step,
  output logic finish,
  output logic halted
);
  seq_state_e state_q, state_d;
  logic       halted_d;

  always_comb begin
    state_d = state_q;
    mem_req = (state_q == S_BUSY);
    step    = mem_req & mem_gnt;
    dev_ack = step;
    finish  = (state_q == S_IDLE) & run & act_en & act_zero;
    if (state_q == S_IDLE) begin
      if (run && act_en && !act_zero && dev_req) state_d = S_BUSY;
    end else if (mem_gnt) begin
      state_d = S_IDLE;
    end
    halted_d = halted;
    if (run)                        halted_d = 1'b0;
    else if (state_q == S_IDLE)     halted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      halted  <= 1'b1;
    end else begin
      state_q <= state_d;
      halted  <= halted_d;
    end
  end
endmodule

// File: rtl/pingpong_dma_chan.sv
`timescale 1ns/1ps
module pingpong_dma_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic [ADDR_W-1:0] dev_fifo_addr,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic              irq
);
  logic [NBUF-1:0]   en_q, en_d, dn_q, dn_d, cnt_zero;
  logic              ab_q, ab_d, run_q, run_d, ie_q, ie_d, dir_q, dir_d;
  logic [1:0]        wid_q, wid_d;
  logic [3:0]        dev_q, dev_d;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] set_v, clr_v;
  logic              set_hit, clr_hit, ctl_en, paddr_en;
  logic              step, finish, halted;
  logic [2:0]        step_bytes;
  logic [ADDR_W-1:0] buf_addr [NBUF];
  logic [CNT_W-1:0]  buf_cnt  [NBUF];

  // descriptors, one per buffer
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    dma_buf_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_desc (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_addr    (reg_wr && reg_addr == REG_AW'(OFF_BASE0 + OFF_STEP*b)),
      .ld_cnt     (reg_wr && reg_addr == REG_AW'(OFF_CNT0  + OFF_STEP*b)),
      .wdata      (reg_wdata),
      .step       (step && (ab_q == 1'(b))),
      .step_bytes (step_bytes),
      .addr_q     (buf_addr[b]),
      .cnt_q      (buf_cnt[b])
    );
    assign cnt_zero[b] = (buf_cnt[b] == '0);
  end

  dma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .act_en   (en_q[ab_q]),
    .act_zero (cnt_zero[ab_q]),
    .dev_req  (dev_req),
    .mem_gnt  (mem_gnt),
    .mem_req  (mem_req),
    .dev_ack  (dev_ack),
    .step     (step),
    .finish   (finish),
    .halted   (halted)
  );

  // control word next state
  always_comb begin
    set_hit  = reg_wr && (reg_addr == REG_AW'(OFF_SET));
    clr_hit  = reg_wr && (reg_addr == REG_AW'(OFF_CLR));
    paddr_en = reg_wr && (reg_addr == REG_AW'(OFF_PADDR));
    set_v    = set_hit ? reg_wdata : '0;
    clr_v    = clr_hit ? reg_wdata : '0;
    ctl_en   = set_hit | clr_hit | finish;
    run_d    = (run_q | set_v[B_RUN]) & ~clr_v[B_RUN];
    ie_d     = (ie_q  | set_v[B_IE])  & ~clr_v[B_IE];
    dir_d    = (dir_q | set_v[B_DIR]) & ~clr_v[B_DIR];
    wid_d    = (wid_q | set_v[B_WID+:2]) & ~clr_v[B_WID+:2];
    dev_d    = (dev_q | set_v[B_DEVID+:4]) & ~clr_v[B_DEVID+:4];
    ab_d     = ab_q ^ finish;
    for (int b = 0; b < NBUF; b++) begin
      en_d[b] = (en_q[b] | set_v[2*b]) & ~clr_v[2*b];
      dn_d[b] = dn_q[b] & ~clr_v[2*b+1];
      if (finish && (ab_q == 1'(b))) begin
        en_d[b] = 1'b0;
        dn_d[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      dn_q  <= '0;
      ab_q  <= 1'b0;
      run_q <= 1'b0;
      ie_q  <= 1'b0;
      dir_q <= 1'b0;
      wid_q <= '0;
      dev_q <= '0;
    end else if (ctl_en) begin
      en_q  <= en_d;
      dn_q  <= dn_d;
      ab_q  <= ab_d;
      run_q <= run_d;
      ie_q  <= ie_d;
      dir_q <= dir_d;
      wid_q <= wid_d;
      dev_q <= dev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        paddr_q <= '0;
    else if (paddr_en) paddr_q <= ADDR_W'(reg_wdata);
  end

  // outputs and read mux
  always_comb begin
    step_bytes    = (wid_q == 2'd0) ? 3'd1 : (wid_q == 2'd1) ? 3'd2 : 3'd4;
    mem_addr      = buf_addr[ab_q];
    mem_write     = dir_q;
    mem_size      = wid_q;
    dev_fifo_addr = paddr_q;
    irq           = ie_q & (|dn_q);
    case (reg_addr)
      REG_AW'(OFF_SET): reg_rdata = DATA_W'({12'b0, dev_q, 3'b0, dir_q, 1'b0, wid_q, 1'b0,
                                             ie_q, halted, run_q, ab_q, dn_q[1], en_q[1],
                                             dn_q[0], en_q[0]});
      REG_AW'(OFF_PADDR):               reg_rdata = DATA_W'(paddr_q);
      REG_AW'(OFF_BASE0):               reg_rdata = DATA_W'(buf_addr[0]);
      REG_AW'(OFF_CNT0):                reg_rdata = DATA_W'(buf_cnt[0]);
      REG_AW'(OFF_BASE0 + OFF_STEP):    reg_rdata = DATA_W'(buf_addr[1]);
      REG_AW'(OFF_CNT0 + OFF_STEP):     reg_rdata = DATA_W'(buf_cnt[1]);
      default:                          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_checks.sv
`timescale 1ns/1ps
module dma_chan_checks
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [1:0]        wr_dn_bits,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dev_ack,
  input logic              irq,
  input logic [1:0]        en_q,
  input logic [1:0]        dn_q,
  input logic [1:0]        cnt_zero,
  input logic              ab_q,
  input logic              run_q,
  input logic              ie_q,
  input logic              halted
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == REG_AW'(OFF_CLR));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  p_ack_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (mem_req && mem_gnt));

  p_zero_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && run_q && (ab_q ? (en_q[1] && cnt_zero[1]) : (en_q[0] && cnt_zero[0])))
    |=> ($past(ab_q) ? dn_q[1] : dn_q[0]));

  p_done0_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_q[0]) |-> $past(clr_wr && wr_dn_bits[0]));

  p_done1_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_q[1]) |-> $past(clr_wr && wr_dn_bits[1]));

  p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dn_q[0]) && ie_q) |-> irq);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  p_halt_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(!run_q));

  p_no_start_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(run_q && (ab_q ? en_q[1] : en_q[0])));
endmodule

bind pingpong_dma_chan dma_chan_checks #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .wr_dn_bits ({reg_wdata[3], reg_wdata[1]}),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .dev_ack    (dev_ack),
  .irq        (irq),
  .en_q       (en_q),
  .dn_q       (dn_q),
  .cnt_zero   (cnt_zero),
  .ab_q       (ab_q),
  .run_q      (run_q),
  .ie_q       (ie_q),
  .halted     (halted)
);

// File: tb/test_pingpong_dma_chan.sv
`timescale 1ns/1ps
module test_pingpong_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_req = 1'b0, dev_ack;
  logic [31:0] dev_fifo_addr;
  logic        mem_req, mem_gnt = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_write;
  logic [1:0]  mem_size;
  logic        irq;
  int          checks = 0;
  int          fails  = 0;

  always #5 clk = ~clk;

  pingpong_dma_chan i_pingpong_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_fifo_addr(dev_fifo_addr), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_write(mem_write),
    .mem_size(mem_size), .irq(irq)
  );

  // {is_read, offset, data, expected}
  localparam int NV = 19;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 5'h00, 32'h0,          32'h0000_0040}, // R2 reset word
    {1'b0, 5'h08, 32'h1234_5678,  32'h0},
    {1'b1, 5'h08, 32'h0,          32'h1234_5678}, // R3
    {1'b0, 5'h10, 32'hABCD_0005,  32'h0},
    {1'b1, 5'h10, 32'h0,          32'h0000_0005}, // R3 count masked
    {1'b0, 5'h00, 32'h0000_0280,  32'h0},
    {1'b1, 5'h00, 32'h0,          32'h0000_02C0}, // R1 set ie, width
    {1'b0, 5'h04, 32'h0000_0080,  32'h0},
    {1'b1, 5'h00, 32'h0,          32'h0000_0240}, // R1 clear ie
    {1'b0, 5'h00, 32'h0000_000A,  32'h0},
    {1'b1, 5'h00, 32'h0,          32'h0000_0240}, // R8 done not settable
    {1'b0, 5'h00, 32'h000F_1000,  32'h0},
    {1'b1, 5'h00, 32'h0,          32'h000F_1240}, // R1 dev id, dir
    {1'b0, 5'h04, 32'hFFFF_FFFF,  32'h0},
    {1'b1, 5'h00, 32'h0,          32'h0000_0040}, // R1 status bits kept
    {1'b0, 5'h18, 32'hFFFF_FFFF,  32'h0},
    {1'b1, 5'h18, 32'h0,          32'h0000_FFFF}, // R3
    {1'b0, 5'h14, 32'h0000_2000,  32'h0},
    {1'b1, 5'h14, 32'h0,          32'h0000_2000}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic unit(input string req, input logic [31:0] ea, input logic ew, input logic [1:0] esz);
    @(negedge clk);
    dev_req = 1'b1;
    for (int n = 0; n < 10 && !mem_req; n++) @(negedge clk);
    chk(req, {31'b0, mem_req}, 32'h1);
    chk(req, mem_addr, ea);
    chk(req, {29'b0, mem_write, mem_size}, {29'b0, ew, esz});
    mem_gnt = 1'b1;
    #1 chk(req, {31'b0, dev_ack}, 32'h1);
    @(negedge clk);
    mem_gnt = 1'b0; dev_req = 1'b0;
  endtask

  task automatic no_req(input string req, input int n);
    int seen = 0;
    dev_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req) seen++;
    end
    dev_req = 1'b0;
    chk(req, seen, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R2 irq at reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) begin
        rd(VEC[i][68:64], v);
        chk($sformatf("R1/R2/R3/R8 vector %0d", i), v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][68:64], VEC[i][63:32]);
      end
    end
    chk("R3 dev_fifo_addr", dev_fifo_addr, 32'h1234_5678);

    // R4 R5 R6 ping-pong, 16-bit units, memory write
    wr(5'h0C, 32'h1000); wr(5'h10, 32'd3);
    wr(5'h14, 32'h2000); wr(5'h18, 32'd2);
    wr(5'h00, 32'h1200);
    wr(5'h00, 32'h00A5);
    @(negedge clk);
    rd(5'h00, v); chk("R10 halted clears after run", v, 32'h0000_12A5);
    unit("R4 b0 unit0", 32'h1000, 1'b1, 2'd1);
    unit("R4 b0 unit1", 32'h1002, 1'b1, 2'd1);
    unit("R4 b0 unit2", 32'h1004, 1'b1, 2'd1);
    repeat (2) @(negedge clk);
    rd(5'h00, v); chk("R5 buffer0 finished", v, 32'h0000_12B6);
    chk("R9 irq on done", {31'b0, irq}, 32'h1);
    rd(5'h10, v); chk("R4 count0 zero", v, 32'h0);
    rd(5'h0C, v); chk("R4 addr0 advanced", v, 32'h1006);
    unit("R6 b1 unit0", 32'h2000, 1'b1, 2'd1);
    unit("R6 b1 unit1", 32'h2002, 1'b1, 2'd1);
    repeat (2) @(negedge clk);
    rd(5'h00, v); chk("R5 buffer1 finished", v, 32'h0000_12AA);
    no_req("R6 idle with other buffer disabled", 5);
    wr(5'h04, 32'h2);
    chk("R8 irq held by done1", {31'b0, irq}, 32'h1);
    wr(5'h04, 32'h8);
    chk("R9 irq low no done", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'd1); wr(5'h00, 32'h1);
    unit("R6 resume buffer0", 32'h1006, 1'b1, 2'd1);
    repeat (2) @(negedge clk);
    wr(5'h04, 32'h2);

    // R7 zero count, interrupts off
    wr(5'h04, 32'h80);
    wr(5'h18, 32'd0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h4;
    @(negedge clk);
    reg_wr = 1'b0;
    no_req("R7 zero count no request", 3);
    rd(5'h00, v); chk("R7 zero count done", v, 32'h0000_1228);
    chk("R9 irq gated by ie", {31'b0, irq}, 32'h0);
    wr(5'h04, 32'h8);

    // R10 halt during an outstanding unit, 32-bit reads
    wr(5'h0C, 32'h3000); wr(5'h10, 32'd4);
    wr(5'h04, 32'h1200); wr(5'h00, 32'h400); wr(5'h00, 32'h1);
    @(negedge clk);
    dev_req = 1'b1;
    for (int n = 0; n < 10 && !mem_req; n++) @(negedge clk);
    chk("R4 32-bit request addr", mem_addr, 32'h3000);
    chk("R4 32-bit read size", {29'b0, mem_write, mem_size}, 32'h2);
    wr(5'h04, 32'h20);
    @(negedge clk);
    rd(5'h00, v); chk("R10 not halted while busy", {31'b0, v[6]}, 32'h0);
    chk("R4 request held", {31'b0, mem_req}, 32'h1);
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    @(negedge clk);
    rd(5'h00, v); chk("R10 halted after unit", {31'b0, v[6]}, 32'h1);
    no_req("R11 no request when stopped", 3);
    rd(5'h10, v); chk("R4 count decremented", v, 32'd3);
    rd(5'h0C, v); chk("R4 address step 4", v, 32'h3004);
    wr(5'h00, 32'h20);
    @(negedge clk);
    rd(5'h00, v); chk("R10 halted clears", {31'b0, v[6]}, 32'h0);
    unit("R10 resume after halt", 32'h3004, 1'b0, 2'd2);

    // R2 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    rd(5'h00, v); chk("R2 word after reset", v, 32'h40);
    rd(5'h10, v); chk("R2 count after reset", v, 32'h0);
    chk("R2 irq after reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule